// File: doc/BRIEF.md
# Block Descriptor Chain Walker

This block sequences one DMA channel through a chain of block descriptors kept in memory. A start pulse supplies the address of the first descriptor. The walker reads the descriptor over a simple word-wide memory master and presents the source address, destination address and both control words to the transfer engine. It then holds a "block go" level until the engine reports that the block is finished.

When the engine reports completion, the walker returns the status of the block to memory. The control-high word is written back first, with its completion flag set. The two status snapshots from the engine follow, each only if the instance is built with it enabled. The walker then either follows the chain pointer to the next descriptor or stops and signals that the whole transfer is complete.

Each descriptor is seven consecutive 32-bit words. Word 0 is the source address, word 1 the destination address, word 2 the next pointer, word 3 control-low, word 4 control-high, word 5 the source status and word 6 the destination status. Words 0 to 3 belong to software and are only ever read.

Top module: `blkdesc_walker`

## Requirements
- R1: After reset the walker is idle: busy_o, mem_req_o, blk_go_o, blk_irq_o and xfer_done_o are all low.
- R2: A start pulse while idle makes the walker read words 0 to 4 of the descriptor, with reads only, in ascending address order. The reads begin at chain_addr_i with its low two bits cleared.
- R3: After word 4 is read, blk_go_o is high. While it is high, src_addr_o, dst_addr_o, ctl_lo_o and ctl_hi_o equal words 0, 1, 3 and 4, and they hold until blk_done_i is seen. blk_go_o is low in the cycle after that.
- R4: The first write after a block finishes goes to word 4. Its data is the fetched control-high word with bit 12 (done) set and bits 11:0 (block size) unchanged.
- R5: The write to word 4 is followed by the status writes. With both enabled, blk_sstat_i (as sampled with blk_done_i) goes to word 5 and blk_dstat_i goes to word 6. Words 0 to 3 are never written.
- R6: blk_irq_o pulses for exactly one cycle after the last write-back of a block, and only when control-low bit 0 of that block is set.
- R7: The chain continues when two conditions hold. The next pointer, with its low two bits ignored, must be nonzero. Control-low bit 27 (destination chaining) or bit 28 (source chaining) must be set. The next descriptor is then fetched from that pointer.
- R8: If the chain does not continue, xfer_done_o pulses for one cycle after the last write-back and the walker returns to idle. The pulse is never given before the final block.
- R9: A start pulse while busy is ignored.
- R10: A memory request holds its address, direction and write data stable until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin walking a chain (only while idle) |
| chain_addr_i | input | 32 | Address of first descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| blk_go_o | output | 1 | Loaded block is ready for the transfer engine |
| blk_done_i | input | 1 | Engine finished the block |
| blk_sstat_i | input | 32 | Source status snapshot, sampled with blk_done_i |
| blk_dstat_i | input | 32 | Destination status snapshot, sampled with blk_done_i |
| src_addr_o | output | 32 | Loaded source address |
| dst_addr_o | output | 32 | Loaded destination address |
| ctl_lo_o | output | 32 | Loaded control-low word |
| ctl_hi_o | output | 32 | Loaded control-high word |
| blk_irq_o | output | 1 | Block-complete pulse |
| xfer_done_o | output | 1 | Chain-complete pulse |
| busy_o | output | 1 | Walker is active |

## Verification
A wrong word index shows up on the memory port at once. It appears as a read outside words 0 to 4 or a write below word 4, and the bench's address log catches it within the same descriptor. A wrong chain decision is also visible one cycle after the final write-back acknowledge, in either of two ways. A continued chain shows as a fetch from the wrong address. A stopped chain shows as a missing or premature xfer_done_o pulse. A fault in the loaded registers shows on the channel outputs for the whole time blk_go_o is high, so it is sampled before the engine completes the block.

// File: rtl/bd_walker_pkg.sv
package bd_walker_pkg;
  localparam int DW        = 32;
  localparam int IDX_W     = 3;
  localparam int HDR_WORDS = 5;

  localparam logic [IDX_W-1:0] IX_SRC = 3'd0;
  localparam logic [IDX_W-1:0] IX_DST = 3'd1;
  localparam logic [IDX_W-1:0] IX_NXT = 3'd2;
  localparam logic [IDX_W-1:0] IX_CLO = 3'd3;
  localparam logic [IDX_W-1:0] IX_CHI = 3'd4;
  localparam logic [IDX_W-1:0] IX_SSS = 3'd5;
  localparam logic [IDX_W-1:0] IX_DSS = 3'd6;
  localparam logic [IDX_W-1:0] IX_END = 3'd7;

  localparam int CLO_IRQ_BIT     = 0;
  localparam int CLO_CHAIN_D_BIT = 27;
  localparam int CLO_CHAIN_S_BIT = 28;
  localparam int CHI_DONE_BIT    = 12;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_RUN   = 2'd2,
    WS_WB    = 2'd3
  } walk_state_e;

  function automatic logic [DW-1:0] word_addr(input logic [DW-1:0] base,
                                              input logic [IDX_W-1:0] ix);
    return base + {{(DW-IDX_W-2){1'b0}}, ix, 2'b00};
  endfunction

  function automatic logic [DW-1:0] align_ptr(input logic [DW-1:0] p);
    logic [DW-1:0] r;
    r = p;
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic chain_on(input logic [DW-1:0] lo,
                                    input logic [DW-1:0] nxt);
    return (align_ptr(nxt) != '0) && (lo[CLO_CHAIN_D_BIT] || lo[CLO_CHAIN_S_BIT]);
  endfunction

  function automatic logic [DW-1:0] mark_done(input logic [DW-1:0] hi);
    logic [DW-1:0] r;
    r = hi;
    r[CHI_DONE_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] next_wb(input logic [IDX_W-1:0] cur,
                                               input logic s_en,
                                               input logic d_en);
    logic [IDX_W-1:0] r;
    r = IX_END;
    if (cur == IX_CHI) begin
      if (s_en)      r = IX_SSS;
      else if (d_en) r = IX_DSS;
    end else if (cur == IX_SSS) begin
      if (d_en) r = IX_DSS;
    end
    return r;
  endfunction
endpackage

// File: rtl/bd_seq.sv
module bd_seq
  import bd_walker_pkg::*;
#(
  parameter bit SRC_WB = 1'b1,
  parameter bit DST_WB = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DW-1:0]     chain_addr_i,
  input  logic              mem_ack_i,
  input  logic              blk_done_i,
  input  logic [DW-1:0]     nxt_ptr_i,
  input  logic [DW-1:0]     ctl_lo_i,
  output walk_state_e       state_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DW-1:0]     addr_o,
  output logic              rd_take_o,
  output logic              blk_end_o,
  output logic              blk_irq_o,
  output logic              xfer_done_o
);
  walk_state_e          state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DW-1:0]        base_q;
  logic                 irq_q, done_q;
  logic [IDX_W-1:0]     wb_next;
  logic                 wb_ack, wb_last, go_on;

  assign wb_next   = next_wb(idx_q, SRC_WB, DST_WB);
  assign wb_ack    = (state_q == WS_WB) && mem_ack_i;
  assign wb_last   = wb_ack && (wb_next == IX_END);
  assign go_on     = chain_on(ctl_lo_i, nxt_ptr_i);
  assign rd_take_o = (state_q == WS_FETCH) && mem_ack_i;
  assign blk_end_o = (state_q == WS_RUN) && blk_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      idx_q   <= IX_SRC;
      base_q  <= '0;
      irq_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: if (start_i) begin
          base_q  <= align_ptr(chain_addr_i);
          idx_q   <= IX_SRC;
          state_q <= WS_FETCH;
        end
        WS_FETCH: if (mem_ack_i) begin
          if (idx_q == IX_CHI) state_q <= WS_RUN;
          else                 idx_q   <= idx_q + 1'b1;
        end
        WS_RUN: if (blk_done_i) begin
          idx_q   <= IX_CHI;
          state_q <= WS_WB;
        end
        WS_WB: if (wb_ack) begin
          if (wb_last) begin
            irq_q <= ctl_lo_i[CLO_IRQ_BIT];
            if (go_on) begin
              base_q  <= align_ptr(nxt_ptr_i);
              idx_q   <= IX_SRC;
              state_q <= WS_FETCH;
            end else begin
              done_q  <= 1'b1;
              state_q <= WS_IDLE;
            end
          end else begin
            idx_q <= wb_next;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign idx_o       = idx_q;
  assign addr_o      = word_addr(base_q, idx_q);
  assign blk_irq_o   = irq_q;
  assign xfer_done_o = done_q;
endmodule

// File: rtl/bd_words.sv
module bd_words
  import bd_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    rdata_i,
  input  logic             cap_i,
  input  logic [DW-1:0]    sstat_i,
  input  logic [DW-1:0]    dstat_i,
  output logic [DW-1:0]    src_o,
  output logic [DW-1:0]    dst_o,
  output logic [DW-1:0]    nxt_o,
  output logic [DW-1:0]    clo_o,
  output logic [DW-1:0]    chi_o,
  output logic [DW-1:0]    sst_o,
  output logic [DW-1:0]    dst_st_o
);
  logic [DW-1:0] w_q [HDR_WORDS];
  logic [DW-1:0] sst_q, dss_q;

  for (genvar k = 0; k < HDR_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             w_q[k] <= '0;
      else if (take_i && idx_i == IDX_W'(k))  w_q[k] <= rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sst_q <= '0;
      dss_q <= '0;
    end else if (cap_i) begin
      sst_q <= sstat_i;
      dss_q <= dstat_i;
    end
  end

  assign src_o    = w_q[IX_SRC];
  assign dst_o    = w_q[IX_DST];
  assign nxt_o    = w_q[IX_NXT];
  assign clo_o    = w_q[IX_CLO];
  assign chi_o    = w_q[IX_CHI];
  assign sst_o    = sst_q;
  assign dst_st_o = dss_q;
endmodule

// File: rtl/bd_wb_mux.sv
module bd_wb_mux
  import bd_walker_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    chi_i,
  input  logic [DW-1:0]    sst_i,
  input  logic [DW-1:0]    dss_i,
  output logic [DW-1:0]    wdata_o
);
  always_comb begin
    unique case (idx_i)
      IX_SSS:  wdata_o = sst_i;
      IX_DSS:  wdata_o = dss_i;
      default: wdata_o = mark_done(chi_i);
    endcase
  end
endmodule

// File: rtl/blkdesc_walker.sv
module blkdesc_walker
  import bd_walker_pkg::*;
#(
  parameter bit SRC_STAT_WB = 1'b1,
  parameter bit DST_STAT_WB = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   chain_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          blk_go_o,
  input  logic          blk_done_i,
  input  logic [31:0]   blk_sstat_i,
  input  logic [31:0]   blk_dstat_i,
  output logic [31:0]   src_addr_o,
  output logic [31:0]   dst_addr_o,
  output logic [31:0]   ctl_lo_o,
  output logic [31:0]   ctl_hi_o,
  output logic          blk_irq_o,
  output logic          xfer_done_o,
  output logic          busy_o
);
  walk_state_e      state;
  logic [IDX_W-1:0] cur_idx;
  logic             rd_take, blk_end;
  logic [DW-1:0]    nxt_ptr, sst_w, dss_w;

  bd_seq #(.SRC_WB(SRC_STAT_WB), .DST_WB(DST_STAT_WB)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_addr_i(chain_addr_i),
    .mem_ack_i(mem_ack_i), .blk_done_i(blk_done_i), .nxt_ptr_i(nxt_ptr),
    .ctl_lo_i(ctl_lo_o), .state_o(state), .idx_o(cur_idx), .addr_o(mem_addr_o),
    .rd_take_o(rd_take), .blk_end_o(blk_end), .blk_irq_o(blk_irq_o),
    .xfer_done_o(xfer_done_o)
  );

  bd_words u_words (
    .clk(clk), .rst_n(rst_n), .take_i(rd_take), .idx_i(cur_idx),
    .rdata_i(mem_rdata_i), .cap_i(blk_end), .sstat_i(blk_sstat_i),
    .dstat_i(blk_dstat_i), .src_o(src_addr_o), .dst_o(dst_addr_o),
    .nxt_o(nxt_ptr), .clo_o(ctl_lo_o), .chi_o(ctl_hi_o), .sst_o(sst_w),
    .dst_st_o(dss_w)
  );

  bd_wb_mux u_wb (
    .idx_i(cur_idx), .chi_i(ctl_hi_o), .sst_i(sst_w), .dss_i(dss_w),
    .wdata_o(mem_wdata_o)
  );

  assign mem_req_o = (state == WS_FETCH) || (state == WS_WB);
  assign mem_we_o  = (state == WS_WB);
  assign blk_go_o  = (state == WS_RUN);
  assign busy_o    = (state != WS_IDLE);
endmodule

// File: rtl/bd_walker_chk.sv
module bd_walker_chk
  import bd_walker_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [31:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             blk_go_o,
  input logic             blk_done_i,
  input logic [31:0]      src_addr_o,
  input logic             busy_o,
  input logic             blk_irq_o,
  input logic             xfer_done_o,
  input logic [IDX_W-1:0] cur_idx
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  // R2
  fetch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_we_o |-> cur_idx <= IX_CHI);
  // R5
  hdr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> cur_idx >= IX_CHI && cur_idx <= IX_DSS);
  // R4
  wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o && cur_idx == IX_CHI |-> mem_wdata_o[CHI_DONE_BIT]);
  // R3
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_go_o && !blk_done_i |=> blk_go_o && $stable(src_addr_o));
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq_o |=> !blk_irq_o);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> !busy_o && !mem_req_o);
endmodule

bind blkdesc_walker bd_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .blk_go_o(blk_go_o), .blk_done_i(blk_done_i), .src_addr_o(src_addr_o),
  .busy_o(busy_o), .blk_irq_o(blk_irq_o), .xfer_done_o(xfer_done_o),
  .cur_idx(cur_idx)
);

// File: tb/tb_blkdesc_walker.sv
module tb_blkdesc_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] chain_addr_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic blk_go_o, blk_done_i = 1'b0;
  logic [31:0] blk_sstat_i = '0, blk_dstat_i = '0;
  logic [31:0] src_addr_o, dst_addr_o, ctl_lo_o, ctl_hi_o;
  logic blk_irq_o, xfer_done_o, busy_o;

  always #4 clk = ~clk;

  blkdesc_walker dut (.*);

  logic [31:0] mem [256];
  logic [31:0] rd_addr [64];
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  int rd_n = 0, wr_n = 0, irq_n = 0, done_n = 0, irq_at_wr = -1, hold_err = 0;
  int lat = 0, wcnt = 0;
  int errors = 0, checks = 0;
  logic pend = 1'b0, pwe = 1'b0;
  logic [31:0] pa = '0;

  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  always @(negedge clk) begin
    if (!mem_req_o) begin
      mem_ack_i = 1'b0;
      wcnt = 0;
    end else if (wcnt >= lat) begin
      mem_ack_i = 1'b1;
      wcnt = 0;
    end else begin
      mem_ack_i = 1'b0;
      wcnt++;
    end
  end

  always @(posedge clk) begin
    if (pend && mem_req_o && (mem_addr_o != pa || mem_we_o != pwe)) hold_err++;
    pend = mem_req_o && !mem_ack_i;
    pa = mem_addr_o;
    pwe = mem_we_o;
    if (mem_req_o && mem_ack_i) begin
      if (mem_we_o) begin
        mem[mem_addr_o[9:2]] = mem_wdata_o;
        wr_addr[wr_n] = mem_addr_o;
        wr_data[wr_n] = mem_wdata_o;
        wr_n++;
      end else begin
        rd_addr[rd_n] = mem_addr_o;
        rd_n++;
      end
    end
    if (blk_irq_o) begin
      irq_n++;
      irq_at_wr = wr_n;
    end
    if (xfer_done_o) done_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] lo,
                          input logic [31:0] hi);
    mem[base/4 + 0] = s;
    mem[base/4 + 1] = d;
    mem[base/4 + 2] = n;
    mem[base/4 + 3] = lo;
    mem[base/4 + 4] = hi;
    mem[base/4 + 5] = 32'hDEAD_0005;
    mem[base/4 + 6] = 32'hDEAD_0006;
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; irq_n = 0; done_n = 0; irq_at_wr = -1;
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk);
    chain_addr_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_block(input logic [31:0] es, input logic [31:0] ed,
                           input logic [31:0] elo, input logic [31:0] ehi,
                           input logic [31:0] ss, input logic [31:0] ds,
                           input bit poke_start);
    while (!blk_go_o) @(negedge clk);
    chk(src_addr_o == es,  "R3 src", src_addr_o, es);
    chk(dst_addr_o == ed,  "R3 dst", dst_addr_o, ed);
    chk(ctl_lo_o   == elo, "R3 ctl_lo", ctl_lo_o, elo);
    chk(ctl_hi_o   == ehi, "R3 ctl_hi", ctl_hi_o, ehi);
    if (poke_start) begin
      chain_addr_i = 32'h40;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(blk_go_o == 1'b1, "R9 go kept", 32'(blk_go_o), 1);
      chk(src_addr_o == es, "R9 src kept", src_addr_o, es);
    end
    repeat (2) @(negedge clk);
    blk_sstat_i = ss;
    blk_dstat_i = ds;
    blk_done_i = 1'b1;
    @(negedge clk);
    blk_done_i = 1'b0;
    chk(blk_go_o == 1'b0, "R3 go drop", 32'(blk_go_o), 0);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0,      "R1 busy", 32'(busy_o), 0);
    chk(mem_req_o == 1'b0,   "R1 req", 32'(mem_req_o), 0);
    chk(blk_go_o == 1'b0,    "R1 go", 32'(blk_go_o), 0);
    chk(blk_irq_o == 1'b0,   "R1 irq", 32'(blk_irq_o), 0);
    chk(xfer_done_o == 1'b0, "R1 done", 32'(xfer_done_o), 0);
  endtask

  task automatic t_single();
    logic [31:0] lo;
    lo = 32'h1800_0001;
    lat = 0;
    clear_logs();
    put_desc(32'h40, 32'h1111_0000, 32'h2222_0000, 32'h0, lo, 32'h0000_0ABC);
    kick(32'h43);
    while (!blk_go_o) @(negedge clk);
    chk(rd_n == 5, "R2 read count", 32'(rd_n), 5);
    for (int k = 0; k < 5; k++)
      chk(rd_addr[k] == 32'h40 + 4*k, "R2 read addr", rd_addr[k], 32'h40 + 4*k);
    run_block(32'h1111_0000, 32'h2222_0000, lo, 32'h0000_0ABC,
              32'h5555_AAAA, 32'h6666_BBBB, 1'b0);
    wait_idle();
    chk(wr_n == 3, "R5 write count", 32'(wr_n), 3);
    chk(wr_addr[0] == 32'h50, "R4 first write addr", wr_addr[0], 32'h50);
    chk(wr_data[0] == 32'h0000_1ABC, "R4 done+size", wr_data[0], 32'h0000_1ABC);
    chk(wr_addr[1] == 32'h54 && wr_data[1] == 32'h5555_AAAA, "R5 sstat", wr_data[1], 32'h5555_AAAA);
    chk(wr_addr[2] == 32'h58 && wr_data[2] == 32'h6666_BBBB, "R5 dstat", wr_data[2], 32'h6666_BBBB);
    chk(mem[16] == 32'h1111_0000 && mem[17] == 32'h2222_0000 && mem[18] == 0 &&
        mem[19] == lo, "R5 header intact", mem[19], lo);
    chk(irq_n == 1, "R6 irq count", 32'(irq_n), 1);
    chk(irq_at_wr == 3, "R6 irq after last write", 32'(irq_at_wr), 3);
    chk(done_n == 1, "R8 done count", 32'(done_n), 1);
    chk(busy_o == 1'b0, "R8 idle", 32'(busy_o), 0);
  endtask

  task automatic t_chain();
    lat = 2;
    clear_logs();
    put_desc(32'h100, 32'hA0, 32'hB0, 32'h203, 32'h0800_0000, 32'h010);
    put_desc(32'h200, 32'hA1, 32'hB1, 32'h300, 32'h1000_0001, 32'h020);
    put_desc(32'h300, 32'hA2, 32'hB2, 32'h400, 32'h0000_0001, 32'h030);
    kick(32'h100);
    run_block(32'hA0, 32'hB0, 32'h0800_0000, 32'h010, 32'h1, 32'h2, 1'b1);
    run_block(32'hA1, 32'hB1, 32'h1000_0001, 32'h020, 32'h3, 32'h4, 1'b0);
    while (!blk_go_o) @(negedge clk);
    chk(done_n == 0, "R8 no early done", 32'(done_n), 0);
    run_block(32'hA2, 32'hB2, 32'h0000_0001, 32'h030, 32'h5, 32'h6, 1'b0);
    wait_idle();
    chk(rd_n == 15, "R7 read count", 32'(rd_n), 15);
    chk(rd_addr[5] == 32'h200, "R7 ptr low bits ignored", rd_addr[5], 32'h200);
    chk(rd_addr[10] == 32'h300, "R7 source chaining", rd_addr[10], 32'h300);
    chk(wr_n == 9, "R5 write count chain", 32'(wr_n), 9);
    chk(mem[32'h110/4] == 32'h1010, "R4 blk0", mem[32'h110/4], 32'h1010);
    chk(mem[32'h310/4] == 32'h1030, "R4 blk2", mem[32'h310/4], 32'h1030);
    chk(mem[32'h218/4] == 32'h4, "R5 dstat blk1", mem[32'h218/4], 32'h4);
    chk(irq_n == 2, "R6 gated irq", 32'(irq_n), 2);
    chk(done_n == 1, "R8 stop on no chain enable", 32'(done_n), 1);
    chk(hold_err == 0, "R10 request hold", 32'(hold_err), 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule